// File: doc/BRIEF.md
# Sixteen-bit ALU with overflow word

This unit performs the arithmetic and logic work of a small 16-bit processor. For each accepted operation it takes a 5-bit operation code, a destination operand `b`, a source operand `a`, and the processor's current overflow word. The overflow word is a full 16-bit register. Arithmetic and shift operations fill it with a carry, a borrow, a high product half, a division fraction, or bits shifted out.

It returns the following registered outputs one clock after the operation is offered:
- the value to write back into `b`, with its write enable;
- the new overflow word, with its write enable;
- a skip request when a conditional test fails;
- an illegal-operation flag;
- the number of execution cycles the operation is charged.

Write-back into the register file, memory operands and the actual skipping of the following instruction belong to the surrounding core.

Top module: `ovf_alu16`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it falls, all outputs are 0. This includes `res_b`, `res_ovf` and `cost`.
- R2: An operation is captured at a rising clock edge with `op_valid` high, and its results appear after that edge. After an edge with `op_valid` low, `res_valid`, both write enables, `skip_next` and `illegal_op` are 0, and `res_b`, `res_ovf` and `cost` keep their previous values.
- R3: Add (0x02) writes b+a mod 2^16 and sets the overflow word to 0x0001 on unsigned carry, else 0. Subtract (0x03) writes b-a and sets it to 0xFFFF on borrow, else 0.
- R4: Add-with-overflow (0x1A) writes b+a+ovf and sets the overflow word to 0x0001 if the true sum exceeds 0xFFFF, else 0. Subtract-with-overflow (0x1B) writes b-a+ovf and sets it to 0xFFFF if the true value is negative, else 0.
- R5: Unsigned multiply (0x04) and signed multiply (0x05) write the low half of the 32-bit product and put the high half in the overflow word.
- R6: Unsigned divide (0x06) writes b/a and sets the overflow word to the low 16 bits of (b·2^16)/a. Signed divide (0x07) does the same on magnitudes, rounds toward zero and negates both when the signs differ. A zero divisor gives 0 for both the result and the overflow word.
- R7: Unsigned remainder (0x08) writes b mod a. Signed remainder (0x09) takes the sign of b. A zero divisor writes 0. Neither touches the overflow word.
- R8: Logical right shift (0x0D), arithmetic right shift (0x0E) and left shift (0x0F) use all 16 bits of a as the shift count. The right shifts put the bits shifted out below bit 0 into the overflow word, left-aligned. The left shift puts the bits shifted above bit 15 into the overflow word. Counts of 16 or more clear the result, or give 0xFFFF for an arithmetic shift of a negative b.
- R9: AND (0x0A), OR (0x0B), XOR (0x0C) and copy (0x01) write the bitwise result or a. Copy variants 0x1E and 0x1F also write a. None of these writes the overflow word, and `res_ovf` then repeats `ovf_in`.
- R10: The eight tests are bits-any (0x10), bits-none (0x11), equal (0x12), not-equal (0x13), unsigned greater (0x14), signed greater (0x15), unsigned less (0x16) and signed less (0x17). A test writes neither b nor the overflow word, passes b through on `res_b`, and raises `skip_next` when it fails.
- R11: `cost` is the charged cycle count:
  - 1 for the logic operations, the plain copy (0x01) and reserved codes;
  - 2 for add, subtract, multiplies, shifts and copy variants;
  - 3 for add/subtract-with-overflow, divides and remainders;
  - 2 for a passing test and 3 for a failing one.
- R12: Codes 0x18, 0x19, 0x1C and 0x1D raise `illegal_op` and write nothing. Code 0x00 belongs to another unit: it writes nothing, is not illegal and costs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Operation offered this cycle |
| opcode | input | 5 | Operation code |
| opnd_b | input | 16 | Destination operand value |
| opnd_a | input | 16 | Source operand value |
| ovf_in | input | 16 | Current overflow word |
| res_valid | output | 1 | Result of an accepted operation is present |
| res_b | output | 16 | Value for b (b itself when not written) |
| res_b_we | output | 1 | Write b |
| res_ovf | output | 16 | New overflow word (ovf_in when not written) |
| res_ovf_we | output | 1 | Write the overflow word |
| skip_next | output | 1 | Failed test: skip the following instruction |
| illegal_op | output | 1 | Reserved operation code |
| cost | output | 2 | Charged cycle count |

## Verification
The output registers present the result of one operation in the same cycle that the next operation is captured. The bench therefore issues every table entry back to back with no idle cycles. Each result is judged while its successor sits on the inputs, so a stale or leaking value from a neighbouring entry shows up as a mismatch. A second coincidence is within one operation: the carry-consuming forms read `ovf_in` while producing a new overflow word. Vectors with a nonzero incoming word check that the result uses it and that the produced word replaces it.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

  localparam int OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_EXT    = 5'h00,
    OPC_COPY   = 5'h01,
    OPC_ADD    = 5'h02,
    OPC_SUB    = 5'h03,
    OPC_UMUL   = 5'h04,
    OPC_SMUL   = 5'h05,
    OPC_UDIV   = 5'h06,
    OPC_SDIV   = 5'h07,
    OPC_UREM   = 5'h08,
    OPC_SREM   = 5'h09,
    OPC_AND    = 5'h0a,
    OPC_OR     = 5'h0b,
    OPC_XOR    = 5'h0c,
    OPC_LSR    = 5'h0d,
    OPC_ASR    = 5'h0e,
    OPC_LSL    = 5'h0f,
    OPC_TANY   = 5'h10,
    OPC_TNONE  = 5'h11,
    OPC_TEQ    = 5'h12,
    OPC_TNE    = 5'h13,
    OPC_TUGT   = 5'h14,
    OPC_TSGT   = 5'h15,
    OPC_TULT   = 5'h16,
    OPC_TSLT   = 5'h17,
    OPC_RSV18  = 5'h18,
    OPC_RSV19  = 5'h19,
    OPC_ADDC   = 5'h1a,
    OPC_SUBC   = 5'h1b,
    OPC_RSV1C  = 5'h1c,
    OPC_RSV1D  = 5'h1d,
    OPC_COPYI  = 5'h1e,
    OPC_COPYD  = 5'h1f
  } opc_e;

endpackage

// File: rtl/ovf_alu_addsub.sv
module ovf_alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] ovf_i,
  output logic [W-1:0] add_r,
  output logic [W-1:0] add_o,
  output logic [W-1:0] sub_r,
  output logic [W-1:0] sub_o,
  output logic [W-1:0] addc_r,
  output logic [W-1:0] addc_o,
  output logic [W-1:0] subc_r,
  output logic [W-1:0] subc_o
);

  logic [W:0]   add_w;
  logic [W:0]   sub_w;
  logic [W+1:0] addc_w;
  logic         subc_neg;

  assign add_w  = {1'b0, b_i} + {1'b0, a_i};
  assign add_r  = add_w[W-1:0];
  assign add_o  = add_w[W] ? W'(1) : '0;

  assign sub_w  = {1'b0, b_i} - {1'b0, a_i};
  assign sub_r  = sub_w[W-1:0];
  assign sub_o  = sub_w[W] ? '1 : '0;

  // three-term sum needs two guard bits
  assign addc_w = {2'b00, b_i} + {2'b00, a_i} + {2'b00, ovf_i};
  assign addc_r = addc_w[W-1:0];
  assign addc_o = (|addc_w[W+1:W]) ? W'(1) : '0;

  // b - a + ovf is negative exactly when b + ovf < a
  assign subc_neg = ({1'b0, b_i} + {1'b0, ovf_i}) < {1'b0, a_i};
  assign subc_r   = b_i - a_i + ovf_i;
  assign subc_o   = subc_neg ? '1 : '0;

endmodule

// File: rtl/ovf_alu_muldiv.sv
module ovf_alu_muldiv #(
  parameter int W = 16
) (
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] umul_lo,
  output logic [W-1:0] umul_hi,
  output logic [W-1:0] smul_lo,
  output logic [W-1:0] smul_hi,
  output logic [W-1:0] udiv_q,
  output logic [W-1:0] udiv_f,
  output logic [W-1:0] sdiv_q,
  output logic [W-1:0] sdiv_f,
  output logic [W-1:0] urem_r,
  output logic [W-1:0] srem_r
);

  localparam int W2 = 2 * W;

  logic [W2-1:0] uprod;
  logic [W2-1:0] sprod;
  logic          a_zero;
  logic [W-1:0]  a_safe;
  logic [W-1:0]  uq, ur, uf;
  logic          b_neg, a_neg, q_neg;
  logic [W-1:0]  b_mag, a_mag;
  logic [W-1:0]  sq, sr, sf;

  // sign-extended operands: the low 2W bits are the signed product
  assign uprod   = {{W{1'b0}}, b_i} * {{W{1'b0}}, a_i};
  assign sprod   = {{W{b_i[W-1]}}, b_i} * {{W{a_i[W-1]}}, a_i};
  assign umul_lo = uprod[W-1:0];
  assign umul_hi = uprod[W2-1:W];
  assign smul_lo = sprod[W-1:0];
  assign smul_hi = sprod[W2-1:W];

  assign a_zero = (a_i == '0);
  assign a_safe = a_zero ? W'(1) : a_i;

  assign uq = b_i / a_safe;
  assign ur = b_i % a_safe;
  assign uf = W'({b_i, {W{1'b0}}} / {{W{1'b0}}, a_safe});

  assign b_neg = b_i[W-1];
  assign a_neg = a_i[W-1];
  assign q_neg = b_neg ^ a_neg;
  assign b_mag = b_neg ? (~b_i + W'(1)) : b_i;
  assign a_mag = a_neg ? (~a_i + W'(1)) : a_safe;

  assign sq = b_mag / a_mag;
  assign sr = b_mag % a_mag;
  assign sf = W'({b_mag, {W{1'b0}}} / {{W{1'b0}}, a_mag});

  assign udiv_q = a_zero ? '0 : uq;
  assign udiv_f = a_zero ? '0 : uf;
  assign urem_r = a_zero ? '0 : ur;
  assign sdiv_q = a_zero ? '0 : (q_neg ? (~sq + W'(1)) : sq);
  assign sdiv_f = a_zero ? '0 : (q_neg ? (~sf + W'(1)) : sf);
  assign srem_r = a_zero ? '0 : (b_neg ? (~sr + W'(1)) : sr);

endmodule

// File: rtl/ovf_alu_shift.sv
module ovf_alu_shift #(
  parameter int W = 16
) (
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] lsr_r,
  output logic [W-1:0] lsr_o,
  output logic [W-1:0] asr_r,
  output logic [W-1:0] asr_o,
  output logic [W-1:0] lsl_r,
  output logic [W-1:0] lsl_o
);

  localparam int W2 = 2 * W;

  logic [W2-1:0] lsr_w, asr_w, lsl_w;

  // double-width shifters: the spare half catches the bits shifted out
  assign lsr_w = {b_i, {W{1'b0}}} >> a_i;
  assign asr_w = $unsigned($signed({b_i, {W{1'b0}}}) >>> a_i);
  assign lsl_w = {{W{1'b0}}, b_i} << a_i;

  assign lsr_r = lsr_w[W2-1:W];
  assign lsr_o = lsr_w[W-1:0];
  assign asr_r = asr_w[W2-1:W];
  assign asr_o = asr_w[W-1:0];
  assign lsl_r = lsl_w[W-1:0];
  assign lsl_o = lsl_w[W2-1:W];

endmodule

// File: rtl/ovf_alu_cmp.sv
module ovf_alu_cmp
  import ovf_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  opc_e         op_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] a_i,
  output logic         is_test,
  output logic         pass
);

  always_comb begin
    is_test = 1'b1;
    pass    = 1'b0;
    case (op_i)
      OPC_TANY:  pass = (b_i & a_i) != '0;
      OPC_TNONE: pass = (b_i & a_i) == '0;
      OPC_TEQ:   pass = b_i == a_i;
      OPC_TNE:   pass = b_i != a_i;
      OPC_TUGT:  pass = b_i > a_i;
      OPC_TSGT:  pass = $signed(b_i) > $signed(a_i);
      OPC_TULT:  pass = b_i < a_i;
      OPC_TSLT:  pass = $signed(b_i) < $signed(a_i);
      default:   is_test = 1'b0;
    endcase
  end

endmodule

// File: rtl/ovf_alu16.sv
module ovf_alu16
  import ovf_alu_pkg::*;
#(
  parameter int W      = 16,
  parameter int COST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [W-1:0]      opnd_b,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      ovf_in,
  output logic              res_valid,
  output logic [W-1:0]      res_b,
  output logic              res_b_we,
  output logic [W-1:0]      res_ovf,
  output logic              res_ovf_we,
  output logic              skip_next,
  output logic              illegal_op,
  output logic [COST_W-1:0] cost
);

  opc_e op;
  assign op = opc_e'(opcode);

  logic [W-1:0] add_r, add_o, sub_r, sub_o, addc_r, addc_o, subc_r, subc_o;
  logic [W-1:0] umul_lo, umul_hi, smul_lo, smul_hi;
  logic [W-1:0] udiv_q, udiv_f, sdiv_q, sdiv_f, urem_r, srem_r;
  logic [W-1:0] lsr_r, lsr_o, asr_r, asr_o, lsl_r, lsl_o;
  logic         is_test, test_pass;

  ovf_alu_addsub #(.W(W)) u_addsub (
    .b_i(opnd_b), .a_i(opnd_a), .ovf_i(ovf_in),
    .add_r(add_r), .add_o(add_o), .sub_r(sub_r), .sub_o(sub_o),
    .addc_r(addc_r), .addc_o(addc_o), .subc_r(subc_r), .subc_o(subc_o)
  );

  ovf_alu_muldiv #(.W(W)) u_muldiv (
    .b_i(opnd_b), .a_i(opnd_a),
    .umul_lo(umul_lo), .umul_hi(umul_hi), .smul_lo(smul_lo), .smul_hi(smul_hi),
    .udiv_q(udiv_q), .udiv_f(udiv_f), .sdiv_q(sdiv_q), .sdiv_f(sdiv_f),
    .urem_r(urem_r), .srem_r(srem_r)
  );

  ovf_alu_shift #(.W(W)) u_shift (
    .b_i(opnd_b), .a_i(opnd_a),
    .lsr_r(lsr_r), .lsr_o(lsr_o), .asr_r(asr_r), .asr_o(asr_o),
    .lsl_r(lsl_r), .lsl_o(lsl_o)
  );

  ovf_alu_cmp #(.W(W)) u_cmp (
    .op_i(op), .b_i(opnd_b), .a_i(opnd_a),
    .is_test(is_test), .pass(test_pass)
  );

  // next-state selection
  logic [W-1:0]      b_d, ovf_d;
  logic              b_we_d, ovf_we_d, skip_d, ill_d;
  logic [COST_W-1:0] cost_d;

  always_comb begin
    b_d      = opnd_b;
    ovf_d    = ovf_in;
    b_we_d   = 1'b0;
    ovf_we_d = 1'b0;
    skip_d   = 1'b0;
    ill_d    = 1'b0;
    cost_d   = '0;
    case (op)
      OPC_COPY:  begin b_d = opnd_a;          b_we_d = 1'b1; cost_d = COST_W'(1); end
      OPC_COPYI,
      OPC_COPYD: begin b_d = opnd_a;          b_we_d = 1'b1; cost_d = COST_W'(2); end
      OPC_AND:   begin b_d = opnd_b & opnd_a; b_we_d = 1'b1; cost_d = COST_W'(1); end
      OPC_OR:    begin b_d = opnd_b | opnd_a; b_we_d = 1'b1; cost_d = COST_W'(1); end
      OPC_XOR:   begin b_d = opnd_b ^ opnd_a; b_we_d = 1'b1; cost_d = COST_W'(1); end
      OPC_ADD:   begin b_d = add_r;  ovf_d = add_o;  b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(2); end
      OPC_SUB:   begin b_d = sub_r;  ovf_d = sub_o;  b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(2); end
      OPC_ADDC:  begin b_d = addc_r; ovf_d = addc_o; b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(3); end
      OPC_SUBC:  begin b_d = subc_r; ovf_d = subc_o; b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(3); end
      OPC_UMUL:  begin b_d = umul_lo; ovf_d = umul_hi; b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(2); end
      OPC_SMUL:  begin b_d = smul_lo; ovf_d = smul_hi; b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(2); end
      OPC_UDIV:  begin b_d = udiv_q;  ovf_d = udiv_f;  b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(3); end
      OPC_SDIV:  begin b_d = sdiv_q;  ovf_d = sdiv_f;  b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(3); end
      OPC_UREM:  begin b_d = urem_r;  b_we_d = 1'b1; cost_d = COST_W'(3); end
      OPC_SREM:  begin b_d = srem_r;  b_we_d = 1'b1; cost_d = COST_W'(3); end
      OPC_LSR:   begin b_d = lsr_r; ovf_d = lsr_o; b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(2); end
      OPC_ASR:   begin b_d = asr_r; ovf_d = asr_o; b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(2); end
      OPC_LSL:   begin b_d = lsl_r; ovf_d = lsl_o; b_we_d = 1'b1; ovf_we_d = 1'b1; cost_d = COST_W'(2); end
      OPC_TANY, OPC_TNONE, OPC_TEQ, OPC_TNE,
      OPC_TUGT, OPC_TSGT, OPC_TULT, OPC_TSLT: begin
        skip_d = ~test_pass;
        cost_d = test_pass ? COST_W'(2) : COST_W'(3);
      end
      OPC_RSV18, OPC_RSV19, OPC_RSV1C, OPC_RSV1D: begin
        ill_d  = 1'b1;
        cost_d = COST_W'(1);
      end
      default: ;
    endcase
  end

  // result registers: strobes every cycle, data under clock enable
  logic              valid_q, b_we_q, ovf_we_q, skip_q, ill_q;
  logic [W-1:0]      b_q, ovf_q;
  logic [COST_W-1:0] cost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      b_we_q   <= 1'b0;
      ovf_we_q <= 1'b0;
      skip_q   <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      valid_q  <= op_valid;
      b_we_q   <= op_valid & b_we_d;
      ovf_we_q <= op_valid & ovf_we_d;
      skip_q   <= op_valid & skip_d;
      ill_q    <= op_valid & ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q    <= '0;
      ovf_q  <= '0;
      cost_q <= '0;
    end else if (op_valid) begin
      b_q    <= b_d;
      ovf_q  <= ovf_d;
      cost_q <= cost_d;
    end
  end

  assign res_valid  = valid_q;
  assign res_b      = b_q;
  assign res_b_we   = b_we_q;
  assign res_ovf    = ovf_q;
  assign res_ovf_we = ovf_we_q;
  assign skip_next  = skip_q;
  assign illegal_op = ill_q;
  assign cost       = cost_q;

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid && !res_b_we && !res_ovf_we && !skip_next && !illegal_op);

  // R2
  issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == OPC_ADD |=> res_ovf == '0 || res_ovf == W'(1));

  // R3
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == OPC_SUB |=> res_ovf == '0 || res_ovf == '1);

  // R6
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == OPC_UDIV && opnd_a == '0 |=> res_b == '0 && res_ovf == '0);

  // R10
  skip_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |-> cost == COST_W'(3) && !res_b_we && !res_ovf_we);

  // R12
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !res_b_we && !res_ovf_we && !skip_next);

endmodule

// File: tb/ovf_alu16_tb.sv
module ovf_alu16_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  opcode;
  logic [15:0] opnd_b, opnd_a, ovf_in;
  logic        res_valid, res_b_we, res_ovf_we, skip_next, illegal_op;
  logic [15:0] res_b, res_ovf;
  logic [1:0]  cost;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ovf_alu16 dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .opnd_b(opnd_b), .opnd_a(opnd_a), .ovf_in(ovf_in),
    .res_valid(res_valid), .res_b(res_b), .res_b_we(res_b_we),
    .res_ovf(res_ovf), .res_ovf_we(res_ovf_we), .skip_next(skip_next),
    .illegal_op(illegal_op), .cost(cost)
  );

  typedef struct packed {
    logic [4:0]  opc;
    logic [15:0] b;
    logic [15:0] a;
    logic [15:0] x;
    logic [15:0] eb;
    logic        ebwe;
    logic [15:0] ex;
    logic        exwe;
    logic        eskip;
    logic        eill;
    logic [1:0]  ecost;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 55;
  localparam vec_t VT [NV] = '{
    // R3 add / subtract
    '{5'h02, 16'hFFFF, 16'h0001, 16'h1234, 16'h0000, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},
    '{5'h02, 16'h1234, 16'h0001, 16'h0000, 16'h1235, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},
    '{5'h03, 16'h0001, 16'h0002, 16'h0000, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},
    '{5'h03, 16'h0005, 16'h0003, 16'h0077, 16'h0002, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3},
    // R4 carry-consuming forms
    '{5'h1a, 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 2'd3, 4'd4},
    '{5'h1a, 16'h0010, 16'h0020, 16'h0005, 16'h0035, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3, 4'd4},
    '{5'h1b, 16'h0000, 16'h0001, 16'h0000, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'd3, 4'd4},
    '{5'h1b, 16'h0005, 16'h0003, 16'hFFFF, 16'h0001, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3, 4'd4},
    // R5 multiplies
    '{5'h04, 16'h1234, 16'h0100, 16'h0000, 16'h3400, 1'b1, 16'h0012, 1'b1, 1'b0, 1'b0, 2'd2, 4'd5},
    '{5'h04, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001, 1'b1, 16'hFFFE, 1'b1, 1'b0, 1'b0, 2'd2, 4'd5},
    '{5'h05, 16'hFFFF, 16'h0002, 16'h0000, 16'hFFFE, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'd2, 4'd5},
    '{5'h05, 16'h8000, 16'h8000, 16'h0000, 16'h0000, 1'b1, 16'h4000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd5},
    // R6 divides
    '{5'h06, 16'h0007, 16'h0002, 16'h0000, 16'h0003, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0, 2'd3, 4'd6},
    '{5'h06, 16'h1234, 16'h0000, 16'h0999, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3, 4'd6},
    '{5'h07, 16'hFFF9, 16'h0002, 16'h0000, 16'hFFFD, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0, 2'd3, 4'd6},
    '{5'h07, 16'h0064, 16'hFFF6, 16'h0000, 16'hFFF6, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3, 4'd6},
    '{5'h07, 16'h8000, 16'hFFFF, 16'h0000, 16'h8000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3, 4'd6},
    '{5'h07, 16'h8000, 16'h0000, 16'h1111, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3, 4'd6},
    // R7 remainders
    '{5'h08, 16'h0007, 16'h0003, 16'h00AA, 16'h0001, 1'b1, 16'h00AA, 1'b0, 1'b0, 1'b0, 2'd3, 4'd7},
    '{5'h08, 16'h0007, 16'h0000, 16'h00AA, 16'h0000, 1'b1, 16'h00AA, 1'b0, 1'b0, 1'b0, 2'd3, 4'd7},
    '{5'h09, 16'hFFF9, 16'h0003, 16'h0000, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd3, 4'd7},
    '{5'h09, 16'h0007, 16'hFFFD, 16'h0000, 16'h0001, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd3, 4'd7},
    '{5'h09, 16'hFFF9, 16'h0000, 16'h2222, 16'h0000, 1'b1, 16'h2222, 1'b0, 1'b0, 1'b0, 2'd3, 4'd7},
    // R8 shifts, including counts of 16 and more
    '{5'h0d, 16'h8001, 16'h0001, 16'h0000, 16'h4000, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    '{5'h0e, 16'h8001, 16'h0001, 16'h0000, 16'hC000, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    '{5'h0f, 16'h8001, 16'h0001, 16'h0000, 16'h0002, 1'b1, 16'h0001, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    '{5'h0d, 16'h1234, 16'h0014, 16'h0000, 16'h0000, 1'b1, 16'h0123, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    '{5'h0e, 16'h8000, 16'h0100, 16'h0000, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    '{5'h0f, 16'h1234, 16'h0010, 16'h0000, 16'h0000, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    '{5'h0d, 16'hFFFF, 16'h1000, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    '{5'h0e, 16'h7FFF, 16'h0020, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    '{5'h0f, 16'hABCD, 16'h0000, 16'h0000, 16'hABCD, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd2, 4'd8},
    // R9 logic and copies leave the overflow word alone
    '{5'h0a, 16'hF0F0, 16'h3C3C, 16'h5555, 16'h3030, 1'b1, 16'h5555, 1'b0, 1'b0, 1'b0, 2'd1, 4'd9},
    '{5'h0b, 16'hF000, 16'h000F, 16'h5555, 16'hF00F, 1'b1, 16'h5555, 1'b0, 1'b0, 1'b0, 2'd1, 4'd9},
    '{5'h0c, 16'hFFFF, 16'h0F0F, 16'h5555, 16'hF0F0, 1'b1, 16'h5555, 1'b0, 1'b0, 1'b0, 2'd1, 4'd9},
    '{5'h01, 16'h1111, 16'hBEEF, 16'h5555, 16'hBEEF, 1'b1, 16'h5555, 1'b0, 1'b0, 1'b0, 2'd1, 4'd9},
    '{5'h1e, 16'h1111, 16'hCAFE, 16'h0042, 16'hCAFE, 1'b1, 16'h0042, 1'b0, 1'b0, 1'b0, 2'd2, 4'd9},
    '{5'h1f, 16'h2222, 16'h0BAD, 16'h0043, 16'h0BAD, 1'b1, 16'h0043, 1'b0, 1'b0, 1'b0, 2'd2, 4'd9},
    // R10 tests, pass and fail for each
    '{5'h10, 16'h0F00, 16'h0100, 16'h0009, 16'h0F00, 1'b0, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd2, 4'd10},
    '{5'h10, 16'h0F00, 16'h00F0, 16'h0009, 16'h0F00, 1'b0, 16'h0009, 1'b0, 1'b1, 1'b0, 2'd3, 4'd10},
    '{5'h11, 16'h0F00, 16'h00F0, 16'h0009, 16'h0F00, 1'b0, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd2, 4'd10},
    '{5'h11, 16'h0F00, 16'h0100, 16'h0009, 16'h0F00, 1'b0, 16'h0009, 1'b0, 1'b1, 1'b0, 2'd3, 4'd10},
    '{5'h12, 16'h0005, 16'h0005, 16'h0009, 16'h0005, 1'b0, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd2, 4'd10},
    '{5'h13, 16'h0005, 16'h0005, 16'h0009, 16'h0005, 1'b0, 16'h0009, 1'b0, 1'b1, 1'b0, 2'd3, 4'd10},
    '{5'h14, 16'h8000, 16'h0001, 16'h0009, 16'h8000, 1'b0, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd2, 4'd10},
    '{5'h15, 16'h8000, 16'h0001, 16'h0009, 16'h8000, 1'b0, 16'h0009, 1'b0, 1'b1, 1'b0, 2'd3, 4'd10},
    '{5'h16, 16'h0001, 16'h8000, 16'h0009, 16'h0001, 1'b0, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd2, 4'd10},
    '{5'h17, 16'h0001, 16'h8000, 16'h0009, 16'h0001, 1'b0, 16'h0009, 1'b0, 1'b1, 1'b0, 2'd3, 4'd10},
    '{5'h17, 16'hFFFF, 16'h0000, 16'h0009, 16'hFFFF, 1'b0, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd2, 4'd10},
    '{5'h15, 16'h0001, 16'hFFFF, 16'h0009, 16'h0001, 1'b0, 16'h0009, 1'b0, 1'b0, 1'b0, 2'd2, 4'd10},
    // R12 reserved codes and the foreign code 0x00
    '{5'h18, 16'h1234, 16'h5678, 16'h0100, 16'h1234, 1'b0, 16'h0100, 1'b0, 1'b0, 1'b1, 2'd1, 4'd12},
    '{5'h19, 16'h1234, 16'h5678, 16'h0100, 16'h1234, 1'b0, 16'h0100, 1'b0, 1'b0, 1'b1, 2'd1, 4'd12},
    '{5'h1c, 16'h1234, 16'h5678, 16'h0100, 16'h1234, 1'b0, 16'h0100, 1'b0, 1'b0, 1'b1, 2'd1, 4'd12},
    '{5'h1d, 16'h1234, 16'h5678, 16'h0100, 16'h1234, 1'b0, 16'h0100, 1'b0, 1'b0, 1'b1, 2'd1, 4'd12},
    '{5'h00, 16'h4321, 16'h8765, 16'h0101, 16'h4321, 1'b0, 16'h0101, 1'b0, 1'b0, 1'b0, 2'd0, 4'd12}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op_valid = 1'b1;
    opcode   = v.opc;
    opnd_b   = v.b;
    opnd_a   = v.a;
    ovf_in   = v.x;
  endtask

  task automatic check_row(input int k);
    vec_t v;
    v = VT[k];
    checks++;
    if (res_valid !== 1'b1 || res_b !== v.eb || res_b_we !== v.ebwe || res_ovf !== v.ex ||
        res_ovf_we !== v.exwe || skip_next !== v.eskip || illegal_op !== v.eill) begin
      fails++;
      $display("FAIL R%0d row %0d: actual vld=%b b=%h bwe=%b ovf=%h owe=%b skip=%b ill=%b expected vld=1 b=%h bwe=%b ovf=%h owe=%b skip=%b ill=%b",
               v.req, k, res_valid, res_b, res_b_we, res_ovf, res_ovf_we, skip_next, illegal_op,
               v.eb, v.ebwe, v.ex, v.exwe, v.eskip, v.eill);
    end
    checks++;
    if (cost !== v.ecost) begin
      fails++;
      $display("FAIL R11 row %0d: actual cost %0d expected %0d", k, cost, v.ecost);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk(tag, "res_valid", 32'(res_valid), 32'd0);
    chk(tag, "write enables", {30'd0, res_b_we, res_ovf_we}, 32'd0);
    chk(tag, "skip/illegal", {30'd0, skip_next, illegal_op}, 32'd0);
    chk(tag, "res_b", 32'(res_b), 32'd0);
    chk(tag, "res_ovf", 32'(res_ovf), 32'd0);
    chk(tag, "cost", 32'(cost), 32'd0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rst_n    = 1'b0;
    op_valid = 1'b0;
    opcode   = '0;
    opnd_b   = '0;
    opnd_a   = '0;
    ovf_in   = '0;
    repeat (3) @(negedge clk);
    // R1 state while held in reset
    check_reset_state("R1");
    rst_n = 1'b1;

    // back-to-back table walk: result of row i-1 judged while row i is offered
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) check_row(i - 1);
      if (i < NV) drive(VT[i]);
      else op_valid = 1'b0;
    end

    // R2 idle cycle: strobes drop, data holds the last row's value
    @(negedge clk);
    chk("R2", "idle res_valid", 32'(res_valid), 32'd0);
    chk("R2", "idle write enables", {30'd0, res_b_we, res_ovf_we}, 32'd0);
    chk("R2", "idle res_b holds", 32'(res_b), 32'h4321);
    opcode = 5'h02;
    opnd_b = 16'hAAAA;
    opnd_a = 16'h5555;
    ovf_in = 16'h7777;
    @(negedge clk);
    chk("R2", "unaccepted inputs ignored res_b", 32'(res_b), 32'h4321);
    chk("R2", "unaccepted inputs ignored res_ovf", 32'(res_ovf), 32'h0101);
    chk("R2", "unaccepted inputs ignored cost", 32'(cost), 32'd0);

    // R1 reset in the middle of a run clears everything at once
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R1", "pre-reset result present", 32'(res_b), 32'hFFFF);
    rst_n = 1'b0;
    #1;
    check_reset_state("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "post-reset idle", 32'(res_valid), 32'd0);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
    end
  end

endmodule